// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Register Bank

The block is a small memory-mapped register bank through which software loads tuning settings into as many as three USB PHYs, one bit at a time. Each PHY holds a 256-entry array of tuning bits. To write one bit, software puts a bit-address and a data value into a shared control word. It then raises the strobe bit that belongs to the target PHY. On the rising edge of that strobe the PHY stores the data value at the addressed position.

A field wider than one bit is loaded least significant bit first. The bit-address goes up by one for each bit, and each bit needs its own strobe pulse. The bank decodes fixed positions of every array into named tuning outputs: transmit amplitude, slew rate, disconnect threshold and squelch enable. Two controls shared by all PHYs, resistor calibration enable and PLL bandwidth, are taken from PHY 0 only. The full arrays are also brought out as one flat vector.

Top module: `phy_tune_bank`

## Requirements
- R1: After reset every tuning bit of every PHY is 0, all four register words read 0, and therefore no strobe is set.
- R2: Word indices 0, 2 and 3 (byte offsets 0x00, 0x08, 0x0c) are plain 32-bit storage. They read back the last value written, and writing them changes no tuning bit.
- R3: The control word (word index 1, byte offset 0x04) reads back exactly the last 32-bit value written to it.
- R4: In the control word, bits [15:8] are the bit-address and bit 7 is the data value. Bit 2n is the strobe of PHY n. When a control word write takes a strobe bit from 0 to 1, that PHY's tuning bit at the bit-address takes the data value. The new value is visible at the outputs after the clock edge that follows the write.
- R5: A strobe that stays at 1 across later control word writes latches only once. A changed address or data value under a held strobe stores nothing.
- R6: A strobe for one PHY leaves every tuning bit of the other PHYs unchanged, and it leaves every other bit of its own PHY unchanged.
- R7: Strobes for several PHYs that rise in the same write each store the same data bit at the same address in every selected PHY.
- R8: Per PHY, the bank decodes these fields from its tuning array: transmit amplitude at bit-addresses 0x20 to 0x21, slew rate at 0x22 to 0x24, disconnect threshold at 0x2a to 0x2b, and a squelch field at 0x3c to 0x3d. The squelch enable output is 1 only when the squelch field is 0, so a field value of 2 turns squelch off. A 5-bit value written at 0x20 loads amplitude and slew together.
- R9: The resistor calibration enable (bit-address 0x0c) and the 2-bit PLL bandwidth (0x03 to 0x04) come from PHY 0 only. Strobes to other PHYs do not change them.
- R10: If the control word is written again in the clock cycle where an earlier strobe rise is committed, the commit uses the address and data of the word that carried the rising strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write enable |
| word_addr_i | input | 2 | Register word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the word at word_addr_i |
| tune_bits_o | output | NUM_PHYS*256 | All tuning arrays; PHY n occupies [n*256 +: 256] |
| tx_amp_o | output | 2*NUM_PHYS | Transmit amplitude per PHY |
| tx_slew_o | output | 3*NUM_PHYS | Slew rate per PHY |
| disc_th_o | output | 2*NUM_PHYS | Disconnect threshold per PHY |
| squelch_en_o | output | NUM_PHYS | Squelch detect enabled per PHY |
| res_cal_en_o | output | 1 | Common resistor calibration enable |
| pll_bw_o | output | 2 | Common PLL bandwidth |

## Verification
Two things can fall in the same clock cycle: a tuning commit caused by a strobe rise, and a fresh write of the control word that changes its address and data. The bench makes this happen by issuing control word writes on back-to-back clock edges, with the strobe dropped in the second write. It then judges the result by checking that only the address from the first word holds the new bit. Simultaneous strobes to all three PHYs and a strobe held high across an address change are judged in the same way, by comparing the full tuning vector against the model.

// File: rtl/phy_tune_pkg.sv
`timescale 1ns/1ps
package phy_tune_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned TADDR_W    = 8;
  localparam int unsigned TBITS      = 1 << TADDR_W;
  localparam int unsigned NUM_WORDS  = 4;
  localparam int unsigned WADDR_W    = $clog2(NUM_WORDS);

  localparam logic [WADDR_W-1:0] W_CTL = 2'd1;
  localparam int unsigned CTL_DATA_BIT = 7;
  localparam int unsigned CTL_ADDR_LSB = 8;

  // tuning field bit-addresses
  localparam int unsigned F_PLL_BW = 'h03;
  localparam int unsigned F_CAL    = 'h0c;
  localparam int unsigned F_AMP    = 'h20;
  localparam int unsigned F_SLEW   = 'h22;
  localparam int unsigned F_DISC   = 'h2a;
  localparam int unsigned F_SQ     = 'h3c;

  typedef struct packed {
    logic [TADDR_W-1:0] addr;
    logic               val;
  } tune_wr_t;
endpackage

// File: rtl/phy_tune_regs.sv
`timescale 1ns/1ps
module phy_tune_regs
  import phy_tune_pkg::*;
#(
  parameter int unsigned NUM_PHYS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [WADDR_W-1:0]  word_addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_PHYS-1:0] stb_rise_o,
  output tune_wr_t            tune_wr_o
);
  logic [DATA_W-1:0]   regs_q [NUM_WORDS];
  logic [NUM_PHYS-1:0] prev_stb_q;
  logic [NUM_PHYS-1:0] stb_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) regs_q[i] <= '0;
    end else if (wr_en_i) begin
      regs_q[word_addr_i] <= wdata_i;
    end
  end

  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_stb
    assign stb_now[n] = regs_q[W_CTL][2*n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_stb_q <= '0;
    else         prev_stb_q <= stb_now;
  end

  assign stb_rise_o     = stb_now & ~prev_stb_q;
  assign tune_wr_o.addr = regs_q[W_CTL][CTL_ADDR_LSB +: TADDR_W];
  assign tune_wr_o.val  = regs_q[W_CTL][CTL_DATA_BIT];
  assign rdata_o        = regs_q[word_addr_i];

  // R3
  ctl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word_addr_i == W_CTL) |=> (regs_q[W_CTL] == $past(wdata_i)));

  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_pulse_chk
    // R5
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_rise_o[n] |=> !stb_rise_o[n]);
  end
endmodule

// File: rtl/phy_tune_array.sv
`timescale 1ns/1ps
module phy_tune_array
  import phy_tune_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  tune_wr_t         wr_i,
  output logic [TBITS-1:0] bits_o
);
  logic [TBITS-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bits_q <= '0;
    else if (stb_i) bits_q[wr_i.addr] <= wr_i.val;
  end

  assign bits_o = bits_q;

  // R4
  latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> (bits_q[$past(wr_i.addr)] == $past(wr_i.val)));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(bits_q));
endmodule

// File: rtl/phy_tune_bank.sv
`timescale 1ns/1ps
module phy_tune_bank
  import phy_tune_pkg::*;
#(
  parameter int unsigned NUM_PHYS = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [1:0]                word_addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic [NUM_PHYS*256-1:0]   tune_bits_o,
  output logic [2*NUM_PHYS-1:0]     tx_amp_o,
  output logic [3*NUM_PHYS-1:0]     tx_slew_o,
  output logic [2*NUM_PHYS-1:0]     disc_th_o,
  output logic [NUM_PHYS-1:0]       squelch_en_o,
  output logic                      res_cal_en_o,
  output logic [1:0]                pll_bw_o
);
  logic [NUM_PHYS-1:0] stb_rise;
  tune_wr_t            tune_wr;

  phy_tune_regs #(.NUM_PHYS(NUM_PHYS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .word_addr_i (word_addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .stb_rise_o  (stb_rise),
    .tune_wr_o   (tune_wr)
  );

  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_phy
    localparam int unsigned B = n * TBITS;
    phy_tune_array u_arr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (stb_rise[n]),
      .wr_i   (tune_wr),
      .bits_o (tune_bits_o[B +: TBITS])
    );
    assign tx_amp_o[2*n +: 2]  = tune_bits_o[B + F_AMP  +: 2];
    assign tx_slew_o[3*n +: 3] = tune_bits_o[B + F_SLEW +: 3];
    assign disc_th_o[2*n +: 2] = tune_bits_o[B + F_DISC +: 2];
    assign squelch_en_o[n]     = (tune_bits_o[B + F_SQ +: 2] == 2'b00);
  end

  // common controls live in PHY 0 only
  assign res_cal_en_o = tune_bits_o[F_CAL];
  assign pll_bw_o     = tune_bits_o[F_PLL_BW +: 2];

  // R9
  common_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_rise[0] |=> ($stable(res_cal_en_o) && $stable(pll_bw_o)));

  // R1
  reset_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (stb_rise == '0));
endmodule

// File: tb/phy_tune_bank_tb_top.sv
`timescale 1ns/1ps
module phy_tune_bank_tb_top;
  localparam int N  = 3;
  localparam int TB = 256;
  localparam int VW = N * TB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    waddr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [VW-1:0] tune_bits;
  logic [2*N-1:0] tx_amp;
  logic [3*N-1:0] tx_slew;
  logic [2*N-1:0] disc_th;
  logic [N-1:0]  sq_en;
  logic          cal_en;
  logic [1:0]    pll_bw;

  phy_tune_bank #(.NUM_PHYS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .word_addr_i(waddr),
    .wdata_i(wdata), .rdata_o(rdata), .tune_bits_o(tune_bits),
    .tx_amp_o(tx_amp), .tx_slew_o(tx_slew), .disc_th_o(disc_th),
    .squelch_en_o(sq_en), .res_cal_en_o(cal_en), .pll_bw_o(pll_bw)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int            due;
    string         req;
    logic [VW-1:0] exp;
  } item_t;
  item_t sb_q[$];
  item_t it;

  logic [VW-1:0] mdl = '0;
  logic [31:0]   last_ctl = '0;
  logic [31:0]   store [4];

  task automatic chk(input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pop due items and compare against outputs
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      logic [VW-1:0] f_act, f_exp;
      it = sb_q.pop_front();
      chk(it.req, "tune_bits", tune_bits, it.exp);
      f_act = '0; f_exp = '0;
      for (int n = 0; n < N; n++) begin
        f_exp[n*16 +: 2]  = it.exp[n*TB + 'h20 +: 2];
        f_exp[n*16+2 +: 3] = it.exp[n*TB + 'h22 +: 3];
        f_exp[n*16+5 +: 2] = it.exp[n*TB + 'h2a +: 2];
        f_exp[n*16+7]      = (it.exp[n*TB + 'h3c +: 2] == 2'b00);
        f_act[n*16 +: 2]  = tx_amp[2*n +: 2];
        f_act[n*16+2 +: 3] = tx_slew[3*n +: 3];
        f_act[n*16+5 +: 2] = disc_th[2*n +: 2];
        f_act[n*16+7]      = sq_en[n];
      end
      f_exp[60] = it.exp['h0c];
      f_exp[61 +: 2] = it.exp['h03 +: 2];
      f_act[60] = cal_en;
      f_act[61 +: 2] = pll_bw;
      chk({it.req, " R8 R9"}, "decoded fields", f_act, f_exp);
    end
  end

  // driver: one register write, model update, expected item push
  task automatic wr(input logic [1:0] wa, input logic [31:0] d, input string req);
    item_t e;
    wr_en = 1'b1; waddr = wa; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    store[wa] = d;
    if (wa == 2'd1) begin
      for (int n = 0; n < N; n++)
        if (d[2*n] && !last_ctl[2*n]) mdl[n*TB + d[15:8]] = d[7];
      last_ctl = d;
    end
    e.due = cyc + 1; e.req = req; e.exp = mdl;
    sb_q.push_back(e);
  endtask

  task automatic rd(input logic [1:0] wa, input string req);
    waddr = wa;
    #1;
    chk(req, "readback", VW'(rdata), VW'(store[wa]));
  endtask

  // serial field write: address, then strobe high, then strobe low, per bit
  task automatic fld(input int phy, input int a, input int val, input int len,
                     input string req);
    for (int i = 0; i < len; i++) begin
      logic [31:0] w;
      w = '0;
      w[15:8] = 8'(a + i);
      w[7] = val[i];
      wr(2'd1, w, req);
      wr(2'd1, w | (32'd1 << (2*phy)), req);
      wr(2'd1, w, req);
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) store[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tune_bits at reset", tune_bits, '0);
    chk("R1", "sq_en at reset", VW'(sq_en), VW'({N{1'b1}}));
    for (int i = 0; i < 4; i++) rd(2'(i), "R1");

    // R2 storage words, no tuning effect
    wr(2'd0, 32'hdead_beef, "R2");
    wr(2'd2, 32'h1234_5678, "R2");
    wr(2'd3, 32'hffff_ffff, "R2");
    drain();
    rd(2'd0, "R2"); rd(2'd2, "R2"); rd(2'd3, "R2");

    // R3 control readback, no strobe bits
    wr(2'd1, 32'ha5a5_00aa, "R3");
    drain();
    rd(2'd1, "R3");
    wr(2'd1, 32'h0, "R3");

    // R4 R8 R9: driver-style init sequences
    fld(0, 'h0c, 1, 1, "R9");
    fld(0, 'h20, 'h14, 5, "R4");
    fld(0, 'h2a, 3, 2, "R8");
    fld(1, 'h20, 'h14, 5, "R6");
    fld(1, 'h2a, 2, 2, "R6");
    fld(2, 'h3c, 2, 2, "R8");
    fld(0, 'h03, 2, 2, "R9");
    fld(2, 'h0c, 1, 1, "R9");
    drain();
    fld(2, 'h3c, 0, 2, "R8");
    fld(1, 'h3c, 2, 2, "R8");

    // R5 held strobe latches once
    wr(2'd1, 32'h0000_5081, "R5");
    wr(2'd1, 32'h0000_5181, "R5");
    wr(2'd1, 32'h0000_5201, "R5");
    wr(2'd1, 32'h0000_5200, "R5");
    drain();

    // R7 simultaneous strobes on all PHYs
    wr(2'd1, 32'h0000_8095, "R7");
    wr(2'd1, 32'h0000_8000, "R7");

    // R10 back-to-back: rewrite lands in the commit cycle
    wr(2'd1, 32'h0000_9084, "R10");
    wr(2'd1, 32'h0000_9100, "R10");
    wr(2'd1, 32'h0000_9291, "R10");
    wr(2'd1, 32'h0000_9310, "R10");
    drain();
    rd(2'd1, "R10");

    // R6 isolation with a clear on PHY 1
    fld(1, 'h21, 0, 1, "R6");
    drain();
    done = 1'b1;
  end

  initial begin
    wait (done || cyc > 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule